// File: doc/BRIEF.md
# Burst-Triggered Comparator Sample Timer

This block paces the sampling of a shared comparator inside a burst-mode optical transmitter. Each time the burst-enable input goes high, a programmable wait runs, then a single-cycle sample strobe is issued. Further strobes follow at a fixed repeat interval until burst-enable drops. A 4-bit rate code picks both the first wait and the repeat interval from one fixed, non-linear table.

The block is clocked by a free-running 20 MHz tick (50 ns), which has no phase relation to burst-enable. Burst-enable therefore goes through a two-stage synchronizer, and edges are taken from the synchronized level. That synchronizer is the source of the one-tick jitter on the first strobe. The rate code is captured when a burst starts, so a code written during a burst is used from the next burst on. The register that holds the code and the comparator itself are outside this block.

Top module: `bst_sample_timer`

## Requirements
- R1: While reset is asserted, and at any time burst-enable has been low since reset, `strobe` is 0.
- R2: If edge 0 is the first clock edge that samples `burstEn` high after it was low, the first strobe is high in the cycle that follows edge F+2, where F is the first-wait tick count of the captured code. It is low before that cycle.
- R3: While `burstEn` stays high, each further strobe comes exactly P cycles after the one before it, where P is the repeat tick count of the captured code.
- R4: Every strobe is high for exactly one clock cycle.
- R5: First-wait tick counts F (code: ticks) are 0:7, 1:11, 2:15, 3:19, 4:27, 5:31, 6:35, 7:43, 8:59, 9:63. These are the waits of 350 ns to 3150 ns at 50 ns per tick.
- R6: Repeat tick counts P (code: ticks) are 0:16, 1:24, 2:32, 3:40, 4:56, 5:64, 6:72, 7:88, 8:120, 9:128. These are the periods of 800 ns to 6400 ns.
- R7: Codes 10 to 15 give the same F and P as code 9.
- R8: Once an edge samples `burstEn` low, no strobe is high in any cycle after the second edge that follows it. A burst that is dropped before its first strobe produces no strobe.
- R9: A new rising edge of `burstEn` after a drop restarts timing from the first wait, as in R2, even if the previous burst was cut off mid-interval.
- R10: `rateCode` is captured together with the rising edge. A change while the burst is running does not change that burst's repeat interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sample tick (20 MHz nominal) |
| rstN | input | 1 | Active-low synchronous reset |
| burstEn | input | 1 | Burst enable, asynchronous to clk |
| rateCode | input | 4 | Selects the first-wait and repeat tick counts |
| strobe | output | 1 | One-cycle comparator sample pulse |

## Verification
Every one of the sixteen codes is run as a held burst of three strobes. This separates the first-wait column from the repeat column and shows that codes 10 to 15 fold onto code 9, not onto some other entry. Three further patterns cover the remaining behaviour. A burst is dropped before its first strobe and must stay silent. A burst is cut mid-interval and raised again, and must time from the first wait and not from the old count. The code is rewritten in the middle of a burst, which tells a captured code apart from a live one. A reset asserted while burst-enable is held high checks that the synchronizer reset produces a clean new start.

// File: rtl/bst_pkg.sv
package bst_pkg;

  // Commands from the control FSM to the datapath, one cycle each
  typedef struct packed {
    logic load;    // capture code, start first wait
    logic reload;  // restart repeat interval
    logic count;   // decrement
    logic clear;   // burst gone: zero the counter
    logic fire;    // issue a strobe
  } ctlCmd_t;

  localparam int CODE_MAX = 9;

  // Waits in ns; codes above CODE_MAX saturate
  function automatic int firstNs(input int code);
    int c;
    c = (code > CODE_MAX) ? CODE_MAX : code;
    case (c)
      0: return 350;
      1: return 550;
      2: return 750;
      3: return 950;
      4: return 1350;
      5: return 1550;
      6: return 1750;
      7: return 2150;
      8: return 2950;
      default: return 3150;
    endcase
  endfunction

  function automatic int repeatNs(input int code);
    int c;
    c = (code > CODE_MAX) ? CODE_MAX : code;
    case (c)
      0: return 800;
      1: return 1200;
      2: return 1600;
      3: return 2000;
      4: return 2800;
      5: return 3200;
      6: return 3600;
      7: return 4400;
      8: return 6000;
      default: return 6400;
    endcase
  endfunction

endpackage

// File: rtl/bst_sync.sv
module bst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prevLevel;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prevLevel <= 1'b0;
    else       prevLevel <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prevLevel;
endmodule

// File: rtl/bst_ctrl.sv
module bst_ctrl
  import bst_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    level,
  input  logic    rise,
  input  logic    cntZero,
  output ctlCmd_t cmd
);
  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  state_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    cmd      = '0;
    stateNxt = state;
    if (!level) begin
      cmd.clear = 1'b1;
      stateNxt  = ST_IDLE;
    end else if (state == ST_IDLE) begin
      if (rise) begin
        cmd.load = 1'b1;
        stateNxt = ST_RUN;
      end
    end else if (cntZero) begin
      cmd.reload = 1'b1;
      cmd.fire   = 1'b1;
    end else begin
      cmd.count = 1'b1;
    end
  end
endmodule

// File: rtl/bst_datapath.sv
module bst_datapath
  import bst_pkg::*;
#(
  parameter int CODE_W  = 4,
  parameter int CNT_W   = 7,
  parameter int TICK_NS = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] rateCode,
  input  ctlCmd_t           cmd,
  output logic              cntZero,
  output logic              strobe
);
  logic [CNT_W-1:0]  cnt;
  logic [CODE_W-1:0] codeHeld;
  logic [CNT_W-1:0]  firstLoad, repeatLoad;

  assign firstLoad  = CNT_W'(firstNs(int'(rateCode)) / TICK_NS - 1);
  assign repeatLoad = CNT_W'(repeatNs(int'(codeHeld)) / TICK_NS - 1);
  assign cntZero    = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      codeHeld <= '0;
      strobe   <= 1'b0;
    end else begin
      strobe <= cmd.fire;
      if (cmd.clear) begin
        cnt <= '0;
      end else if (cmd.load) begin
        cnt      <= firstLoad;
        codeHeld <= rateCode;
      end else if (cmd.reload) begin
        cnt <= repeatLoad;
      end else if (cmd.count) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/bst_sample_timer.sv
module bst_sample_timer
  import bst_pkg::*;
#(
  parameter int CODE_W      = 4,
  parameter int CNT_W       = 7,
  parameter int SYNC_STAGES = 2,
  parameter int TICK_NS     = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              burstEn,
  input  logic [CODE_W-1:0] rateCode,
  output logic              strobe
);
  logic    enLevel, enRise, cntZero;
  ctlCmd_t cmd;

  bst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .din(burstEn), .level(enLevel), .rise(enRise)
  );

  bst_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .level(enLevel), .rise(enRise),
    .cntZero(cntZero), .cmd(cmd)
  );

  bst_datapath #(.CODE_W(CODE_W), .CNT_W(CNT_W), .TICK_NS(TICK_NS)) u_dp (
    .clk(clk), .rstN(rstN), .rateCode(rateCode), .cmd(cmd),
    .cntZero(cntZero), .strobe(strobe)
  );
endmodule

// File: rtl/bst_sample_timer_chk.sv
module bst_sample_timer_chk (
  input logic clk,
  input logic rstN,
  input logic burstEn,
  input logic strobe
);
  logic [7:0] sinceStrobe;
  logic [7:0] sinceReset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceStrobe <= 8'hFF;
      sinceReset  <= 8'd0;
    end else begin
      if (strobe)                   sinceStrobe <= 8'd1;
      else if (sinceStrobe != 8'hFF) sinceStrobe <= sinceStrobe + 8'd1;
      if (sinceReset != 8'hFF)       sinceReset  <= sinceReset + 8'd1;
    end
  end

  // R4
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe |=> !strobe);

  // R8
  needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe |-> $past(burstEn, 3));

  // R2
  min_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe |-> (sinceStrobe >= 8'd9));

  // R1
  after_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe |-> (sinceReset >= 8'd9));
endmodule

bind bst_sample_timer bst_sample_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .burstEn(burstEn), .strobe(strobe)
);

// File: tb/sim_bst_sample_timer.sv
module sim_bst_sample_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       burstEn = 1'b0;
  logic [3:0] rateCode = 4'd0;
  logic       strobe;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  // code, first-wait ticks, repeat ticks (R5, R6, R7)
  localparam int VEC [16][3] = '{
    '{0, 7, 16},   '{1, 11, 24},  '{2, 15, 32},  '{3, 19, 40},
    '{4, 27, 56},  '{5, 31, 64},  '{6, 35, 72},  '{7, 43, 88},
    '{8, 59, 120}, '{9, 63, 128}, '{10, 63, 128}, '{11, 63, 128},
    '{12, 63, 128}, '{13, 63, 128}, '{14, 63, 128}, '{15, 63, 128}
  };

  always #2 clk = ~clk;

  bst_sample_timer u0 (
    .clk(clk), .rstN(rstN), .burstEn(burstEn), .rateCode(rateCode), .strobe(strobe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Raise burstEn; cycle c=1 is the sample after edge 0.
  // The first strobe is expected at c = F+3.
  task automatic runBurst(input int code, input int f, input int p, input int midCode,
                          input string req);
    int t1 = -1, t2 = -1, t3 = -1, n = 0;
    @(negedge clk);
    rateCode = 4'(code);
    burstEn  = 1'b1;
    for (int c = 1; c <= f + 3 + 2 * p + 1; c++) begin
      @(posedge clk); #1;
      if (strobe) begin
        n++;
        if (n == 1) begin
          t1 = c;
          if (midCode >= 0) rateCode = 4'(midCode);
        end else if (n == 2) t2 = c;
        else if (n == 3) t3 = c;
      end
    end
    check(t1 == f + 3, {req, " R2 first strobe"}, t1, f + 3);
    check(t2 - t1 == p, {req, " R3 repeat 1"}, t2 - t1, p);
    check(t3 - t2 == p, {req, " R3 repeat 2"}, t3 - t2, p);
    check(n == 3, {req, " R4 strobe count"}, n, 3);
  endtask

  task automatic dropBurst(input string req);
    int n = 0;
    @(negedge clk);
    burstEn = 1'b0;
    @(posedge clk);
    @(posedge clk);
    for (int c = 0; c < 200; c++) begin
      @(posedge clk); #1;
      if (strobe) n++;
    end
    check(n == 0, {req, " R8 silent after drop"}, n, 0);
  endtask

  // Counts cycles from a raise to the first strobe (0 if none)
  task automatic firstAfterRaise(input int limit, output int at);
    at = 0;
    @(negedge clk);
    burstEn = 1'b1;
    for (int c = 1; c <= limit; c++) begin
      @(posedge clk); #1;
      if (strobe && at == 0) at = c;
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int at, n;
    // R1: reset state
    repeat (4) @(posedge clk);
    #1 check(strobe == 1'b0, "R1 strobe in reset", strobe, 0);
    @(negedge clk);
    rstN = 1'b1;
    n = 0;
    for (int c = 0; c < 40; c++) begin
      @(posedge clk); #1;
      if (strobe) n++;
    end
    check(n == 0, "R1 idle with enable low", n, 0);

    // Table walk: R5 R6 R7
    for (int i = 0; i < 16; i++) begin
      runBurst(VEC[i][0], VEC[i][1], VEC[i][2], -1, $sformatf("R5 R6 R7 code %0d", i));
      dropBurst($sformatf("code %0d", i));
    end

    // R10: code rewritten mid-burst keeps the captured period
    runBurst(0, 7, 16, 9, "R10 mid-burst change");
    dropBurst("R10");
    runBurst(9, 63, 128, -1, "R10 next burst uses new code");
    dropBurst("R10b");

    // R8: drop before first strobe
    firstAfterRaise(20, at);
    check(at == 0, "R8 no strobe before drop", at, 0);
    dropBurst("R8 early drop");

    // R9: cut mid-interval, then raise again
    rateCode = 4'd2;
    firstAfterRaise(25, at);
    check(at == 18, "R9 first burst first strobe", at, 18);
    @(negedge clk);
    burstEn = 1'b0;
    repeat (4) @(negedge clk);
    firstAfterRaise(40, at);
    check(at == 18, "R9 restart from first wait", at, 18);
    dropBurst("R9");

    // R1 and R2: reset while enable held high
    rateCode = 4'd0;
    firstAfterRaise(30, at);
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk); #1;
    check(strobe == 1'b0, "R1 strobe cleared by reset", strobe, 0);
    @(negedge clk);
    rstN = 1'b1;
    at = 0;
    for (int c = 1; c <= 20; c++) begin
      @(posedge clk); #1;
      if (strobe && at == 0) at = c;
    end
    check(at == 10, "R2 fresh start after reset", at, 10);
    dropBurst("post-reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule